// File: doc/BRIEF.md
# Region-Based Sharer Predictor

This block sits beside one core's private cache and guesses which remote core will supply the data for a cache miss. It keeps its guesses per aligned 1 KB region of address space rather than per line. A sharer learned from one 64-byte line therefore also covers later misses to the other fifteen lines of the same region.

On every miss the block looks up the region in a direct-mapped table and issues one request, one clock cycle later.
- **Direct issue.** If the table names a remote core, the request is marked direct. The cache fabric sends it straight to that core and, at the same time, sends a notification to the directory. The directory stays the only ordering point, so the access still completes only after the directory's acknowledgement.
- **Directory issue.** With no usable prediction, the request goes to the directory alone. The directory forwards it to the owner.

The table is trained in two ways:
- **Data responses.** Each arriving data response records the core that sent it as the sharer of that region.
- **Directory corrections.** The directory can report a wrong prediction. It then either invalidates the entry or overwrites it with the core that really holds the data.

Top module: `regionPredTop`

## Requirements
- R1: While reset is low, and in the first cycle after it, `issValid` is 0. Reset empties the whole table, so the first miss to any region after reset is issued with `issDirect` = 0.
- R2: A miss presented in cycle t produces `issValid` = 1 in cycle t+1, with `issAddr` equal to the miss address. A cycle with no miss gives `issValid` = 0 in the next cycle.
- R3: A miss whose region has no valid entry, or whose entry holds a different tag, is issued with `issDirect` = 0 and `issCore` = 0, meaning directory only.
- R4: A miss whose region matches a valid entry naming a remote core is issued with `issDirect` = 1 and `issCore` = that core. This means a request to that core plus a notification to the directory.
- R5: Region granularity depends on the address fields as follows:
  - The region number is address bits [ADDR_W-1:10]; bits [9:0] play no part in the lookup.
  - The table index is address bits [10+IDX_W-1:10].
  - The tag is the bits above the index.
- R6: A data response (`rspValid`) writes its region (`rspRegion`, the address bits above bit 9) into the entry at that region's index, marks the entry valid, and records `rspCore`.
- R7: An entry that names the local core (`selfId`) is treated as no prediction: `issDirect` = 0 and `issCore` = 0.
- R8: A directory correction (`fixValid`) acts on the entry for `fixRegion`:
  - With `fixKill` = 1 it invalidates that entry.
  - With `fixKill` = 0 it overwrites the entry with `fixRegion`'s tag and `fixCore`, marked valid.
- R9: A write to an entry in the same cycle as a lookup of that entry takes effect first; the lookup sees the newly written value.
- R10: When a response and a correction hit the same index in the same cycle, the correction is the value stored and the value the lookup sees.
- R11: Two regions sharing an index displace each other: the later write replaces the entry, and a miss to the displaced region is issued to the directory only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selfId | input | CORE_W | ID of the local core |
| missValid | input | 1 | Cache miss presented this cycle |
| missAddr | input | ADDR_W | Byte address of the miss |
| rspValid | input | 1 | Data response observed this cycle |
| rspRegion | input | ADDR_W-10 | Region number of the response address |
| rspCore | input | CORE_W | Core that supplied the data |
| fixValid | input | 1 | Directory correction this cycle |
| fixKill | input | 1 | 1 invalidates the entry, 0 overwrites it |
| fixRegion | input | ADDR_W-10 | Region number the correction applies to |
| fixCore | input | CORE_W | Core named by the directory |
| issValid | output | 1 | Request issued this cycle |
| issDirect | output | 1 | 1 = direct to issCore plus directory notification, 0 = directory only |
| issCore | output | CORE_W | Predicted core, 0 when not direct |
| issAddr | output | ADDR_W | Address of the issued request |

## Verification
A corrupted entry shows up at the ports only on the next miss to that region. It appears one cycle after that miss, as a wrong `issDirect` or `issCore`. The stimulus therefore follows every training event (response, correction, kill) with a miss to the same region, or to a neighbouring line in that region, in the same cycle or the next.

The same-cycle cases are driven together with a lookup so that a missing bypass or a wrong write priority is visible at once:
- a response arriving with a lookup of the same region;
- a response colliding with a correction on the same index.

The bench also reads back the stored value one cycle later, so a bypass that hides a wrong write is caught as well.

// File: rtl/regionPredPkg.sv
package regionPredPkg;

  // Log2 of the region size in bytes (1 KB regions).
  localparam int REGION_LSB = 10;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic issue;   // register a request this cycle
    logic direct;  // request goes straight to the predicted core
    logic rspWr;   // train the table from a data response
    logic fixWr;   // apply a directory correction
    logic fixKill; // correction invalidates instead of overwriting
  } predStrobe_t;

endpackage

// File: rtl/predCtrl.sv
module predCtrl
  import regionPredPkg::*;
#(
  parameter int CORE_W = 4
) (
  input  logic              missValid,
  input  logic              rspValid,
  input  logic              fixValid,
  input  logic              fixKill,
  input  logic              lookHit,
  input  logic [CORE_W-1:0] lookCore,
  input  logic [CORE_W-1:0] selfId,
  output predStrobe_t       strobe
);

  always_comb begin
    strobe.issue = missValid;

    // Direct only on a region hit that names a remote core (R4, R7).
    strobe.direct = missValid && lookHit && (lookCore != selfId);

    strobe.rspWr = rspValid;
    strobe.fixWr = fixValid;
    strobe.fixKill = fixValid && fixKill;
  end

endmodule

// File: rtl/predData.sv
module predData
  import regionPredPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int CORE_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  predStrobe_t                strobe,
  input  logic [CORE_W-1:0]          selfId,
  input  logic [ADDR_W-1:0]          missAddr,
  input  logic [ADDR_W-REGION_LSB-1:0] rspRegion,
  input  logic [CORE_W-1:0]          rspCore,
  input  logic [ADDR_W-REGION_LSB-1:0] fixRegion,
  input  logic [CORE_W-1:0]          fixCore,
  output logic                       lookHit,
  output logic [CORE_W-1:0]          lookCore,
  output logic                       issValid,
  output logic                       issDirect,
  output logic [CORE_W-1:0]          issCore,
  output logic [ADDR_W-1:0]          issAddr
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int REG_W = ADDR_W - REGION_LSB;
  localparam int TAG_W = REG_W - IDX_W;

  logic              entValid [ENTRIES];
  logic [TAG_W-1:0]  entTag   [ENTRIES];
  logic [CORE_W-1:0] entCore  [ENTRIES];

  logic              nxtValid [ENTRIES];
  logic [TAG_W-1:0]  nxtTag   [ENTRIES];
  logic [CORE_W-1:0] nxtCore  [ENTRIES];

  logic [REG_W-1:0] missRegion;
  logic [IDX_W-1:0] missIdx, rspIdx, fixIdx;
  logic [TAG_W-1:0] missTag, rspTag, fixTag;

  // Split each region number into index (low bits) and tag (R5).
  assign missRegion = missAddr[ADDR_W-1:REGION_LSB];
  assign missIdx = missRegion[IDX_W-1:0];
  assign missTag = missRegion[REG_W-1:IDX_W];
  assign rspIdx = rspRegion[IDX_W-1:0];
  assign rspTag = rspRegion[REG_W-1:IDX_W];
  assign fixIdx = fixRegion[IDX_W-1:0];
  assign fixTag = fixRegion[REG_W-1:IDX_W];

  // Next table state; the correction outranks a response (R10).
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      nxtValid[e] = entValid[e];
      nxtTag[e] = entTag[e];
      nxtCore[e] = entCore[e];

      if (strobe.fixWr && (fixIdx == IDX_W'(e))) begin
        nxtValid[e] = !strobe.fixKill;
        nxtTag[e] = fixTag;
        nxtCore[e] = fixCore;
      end else if (strobe.rspWr && (rspIdx == IDX_W'(e))) begin
        nxtValid[e] = 1'b1;
        nxtTag[e] = rspTag;
        nxtCore[e] = rspCore;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        entValid[e] <= 1'b0;
        entTag[e] <= '0;
        entCore[e] <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        entValid[e] <= nxtValid[e];
        entTag[e] <= nxtTag[e];
        entCore[e] <= nxtCore[e];
      end
    end
  end

  // The lookup reads the post-write view, so same-cycle updates win (R9).
  assign lookHit = nxtValid[missIdx] && (nxtTag[missIdx] == missTag);
  assign lookCore = nxtCore[missIdx];

  // Registered request, one cycle after the miss.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issValid <= 1'b0;
      issDirect <= 1'b0;
      issCore <= '0;
      issAddr <= '0;
    end else begin
      issValid <= strobe.issue;
      issDirect <= strobe.issue && strobe.direct;
      issCore <= (strobe.issue && strobe.direct) ? lookCore : '0;
      if (strobe.issue) issAddr <= missAddr;
    end
  end

  AST_ISSUE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |=> issValid && (issAddr == $past(missAddr))); // R2
  AST_NO_SPURIOUS_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.issue |=> !issValid); // R2
  AST_NOPRED_CORE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !issDirect) |-> (issCore == '0)); // R3
  AST_DIRECT_NOT_SELF: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && issDirect) |-> (issCore != selfId)); // R7
  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fixKill |=> !entValid[$past(fixIdx)]); // R8
  AST_FIX_STORES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fixWr && !strobe.fixKill) |=>
      (entValid[$past(fixIdx)] && (entCore[$past(fixIdx)] == $past(fixCore)))); // R10
  AST_RSP_STORES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rspWr && !(strobe.fixWr && (fixIdx == rspIdx))) |=>
      (entValid[$past(rspIdx)] && (entCore[$past(rspIdx)] == $past(rspCore)))); // R6

endmodule

// File: rtl/regionPredTop.sv
module regionPredTop
  import regionPredPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int CORES   = 16,
  localparam int CORE_W = $clog2(CORES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CORE_W-1:0]            selfId,
  input  logic                         missValid,
  input  logic [ADDR_W-1:0]            missAddr,
  input  logic                         rspValid,
  input  logic [ADDR_W-REGION_LSB-1:0] rspRegion,
  input  logic [CORE_W-1:0]            rspCore,
  input  logic                         fixValid,
  input  logic                         fixKill,
  input  logic [ADDR_W-REGION_LSB-1:0] fixRegion,
  input  logic [CORE_W-1:0]            fixCore,
  output logic                         issValid,
  output logic                         issDirect,
  output logic [CORE_W-1:0]            issCore,
  output logic [ADDR_W-1:0]            issAddr
);

  predStrobe_t strobe;
  logic lookHit;
  logic [CORE_W-1:0] lookCore;

  predCtrl #(.CORE_W(CORE_W)) u_ctrl (
    .missValid(missValid),
    .rspValid(rspValid),
    .fixValid(fixValid),
    .fixKill(fixKill),
    .lookHit(lookHit),
    .lookCore(lookCore),
    .selfId(selfId),
    .strobe(strobe)
  );

  predData #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CORE_W(CORE_W)) u_data (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .selfId(selfId),
    .missAddr(missAddr),
    .rspRegion(rspRegion),
    .rspCore(rspCore),
    .fixRegion(fixRegion),
    .fixCore(fixCore),
    .lookHit(lookHit),
    .lookCore(lookCore),
    .issValid(issValid),
    .issDirect(issDirect),
    .issCore(issCore),
    .issAddr(issAddr)
  );

endmodule

// File: tb/regionPredTop_bench.sv
module regionPredTop_bench;

  localparam int NV = 15;

  typedef struct packed {
    logic        mv;
    logic [31:0] ma;
    logic        rv;
    logic [31:0] ra;
    logic [3:0]  rc;
    logic        fv;
    logic        fk;
    logic [31:0] fa;
    logic [3:0]  fc;
    logic        ev;
    logic        ed;
    logic [3:0]  ec;
  } vec_t;

  function automatic vec_t mkV(
    logic mv, logic [31:0] ma,
    logic rv, logic [31:0] ra, logic [3:0] rc,
    logic fv, logic fk, logic [31:0] fa, logic [3:0] fc,
    logic ev, logic ed, logic [3:0] ec);
    mkV = '{mv, ma, rv, ra, rc, fv, fk, fa, fc, ev, ed, ec};
  endfunction

  // selfId = 5; 16 entries: index = addr[13:10], tag = addr[31:14].
  localparam vec_t VECS [NV] = '{
    mkV(1, 32'h1000,  0, 0, 0,           0, 0, 0, 0,            1, 0, 0),  // R3 empty
    mkV(0, 0,         1, 32'h1040, 3,    0, 0, 0, 0,            0, 0, 0),  // R6 train
    mkV(1, 32'h13C0,  0, 0, 0,           0, 0, 0, 0,            1, 1, 3),  // R4 R5 same region
    mkV(1, 32'h11000, 0, 0, 0,           0, 0, 0, 0,            1, 0, 0),  // R3 tag mismatch
    mkV(1, 32'h11000, 1, 32'h11000, 7,   0, 0, 0, 0,            1, 1, 7),  // R9 bypass
    mkV(1, 32'h1000,  0, 0, 0,           0, 0, 0, 0,            1, 0, 0),  // R11 displaced
    mkV(1, 32'h2000,  1, 32'h2000, 5,    0, 0, 0, 0,            1, 0, 0),  // R7 self
    mkV(1, 32'h11000, 0, 0, 0,           1, 0, 32'h11000, 9,    1, 1, 9),  // R8 overwrite
    mkV(0, 0,         0, 0, 0,           1, 1, 32'h11000, 0,    0, 0, 0),  // R8 kill
    mkV(1, 32'h11000, 0, 0, 0,           0, 0, 0, 0,            1, 0, 0),  // R8 killed
    mkV(1, 32'h3000,  1, 32'h3000, 2,    1, 0, 32'h3000, 11,    1, 1, 11), // R10 fix wins
    mkV(1, 32'h3004,  0, 0, 0,           0, 0, 0, 0,            1, 1, 11), // R10 stored
    mkV(0, 0,         1, 32'h3000, 2,    1, 1, 32'h3000, 0,     0, 0, 0),  // R10 kill wins
    mkV(1, 32'h3000,  0, 0, 0,           0, 0, 0, 0,            1, 0, 0),  // R10 killed
    mkV(1, 32'h2000,  0, 0, 0,           0, 0, 0, 0,            1, 0, 0)   // R7 stored self
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] selfId = 4'd5;
  logic missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic rspValid = 1'b0;
  logic [21:0] rspRegion = '0;
  logic [3:0] rspCore = '0;
  logic fixValid = 1'b0;
  logic fixKill = 1'b0;
  logic [21:0] fixRegion = '0;
  logic [3:0] fixCore = '0;
  logic issValid, issDirect;
  logic [3:0] issCore;
  logic [31:0] issAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regionPredTop u_regionPredTop (
    .clk(clk), .rstN(rstN), .selfId(selfId),
    .missValid(missValid), .missAddr(missAddr),
    .rspValid(rspValid), .rspRegion(rspRegion), .rspCore(rspCore),
    .fixValid(fixValid), .fixKill(fixKill), .fixRegion(fixRegion), .fixCore(fixCore),
    .issValid(issValid), .issDirect(issDirect), .issCore(issCore), .issAddr(issAddr)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    missValid = v.mv;
    missAddr = v.ma;
    rspValid = v.rv;
    rspRegion = v.ra[31:10];
    rspCore = v.rc;
    fixValid = v.fv;
    fixKill = v.fk;
    fixRegion = v.fa[31:10];
    fixCore = v.fc;
  endtask

  task automatic idle();
    drive('0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset state (R1).
    repeat (2) @(negedge clk);
    chk("R1", "issValid in reset", 32'(issValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "issValid after reset", 32'(issValid), 32'd0);

    // Vector table: drive at a negedge, observe at the following negedge.
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      chk("R2", $sformatf("v%0d issValid", i), 32'(issValid), 32'(VECS[i].ev));
      if (VECS[i].ev) begin
        chk("R2", $sformatf("v%0d issAddr", i), issAddr, VECS[i].ma);
        chk(VECS[i].ed ? "R4" : "R3", $sformatf("v%0d issDirect", i),
            32'(issDirect), 32'(VECS[i].ed));
        chk(VECS[i].ed ? "R4" : "R3", $sformatf("v%0d issCore", i),
            32'(issCore), 32'(VECS[i].ec));
      end
    end

    // R5: last line of a trained region and an address in another index.
    drive(mkV(0, 0, 1, 32'h7000, 6, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    drive(mkV(1, 32'h73FF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R5", "last byte of region direct", 32'(issDirect), 32'd1);
    chk("R5", "last byte of region core", 32'(issCore), 32'd6);
    drive(mkV(1, 32'h7400, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R5", "next region not predicted", 32'(issDirect), 32'd0);

    // R1: reset empties a trained entry.
    drive(mkV(0, 0, 1, 32'h5000, 1, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    idle();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    drive(mkV(1, 32'h5000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R1", "miss after reset issued", 32'(issValid), 32'd1);
    chk("R1", "table empty after reset", 32'(issDirect), 32'd0);
    idle();
    @(negedge clk);
    chk("R2", "no miss no issue", 32'(issValid), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule